// File: doc/BRIEF.md
# Breakpoint Match Unit

This block holds a bank of 16-bit breakpoint values and compares them every clock cycle against what the CPU is doing on its buses. The first group of breakpoints (four by default) only ever watches the program execution address, qualified by an instruction-fetch-valid strobe. The second group (two by default) is flexible. Each of these can be switched, one by one, between watching data memory access addresses and watching register access identifiers. In each case the compare is qualified by that access's own strobe.

A single global enable gates every comparator. When an enabled breakpoint matches, the block emits a one-cycle registered break pulse together with the index of the breakpoint that fired. If several fire in the same cycle, the lowest index is reported. A breakpoint that has fired stays quiet while its qualifying strobe remains asserted, and it re-arms once that strobe drops. Breakpoint values and the control word are loaded through a simple select/data write port. The logic that halts the CPU and the host-side debug interface sit outside this block.

Top module: `brk_match_unit`

## Requirements
- R1: After reset every breakpoint value is 0, the global enable is off, every flexible breakpoint is in data-address mode, `brk_pulse` is 0 and `brk_idx` is 0.
- R2: A write with `cfg_we` high and `cfg_sel` = i (0 to 5) loads `cfg_wdata` into breakpoint i. `cfg_sel` = 6 loads the control word: bit 0 is the global enable, bit 1 is the mode of breakpoint 4 and bit 2 is the mode of breakpoint 5 (0 = data address, 1 = register access). A written value is first used for comparison in the cycle after the write.
- R3: Breakpoints 0 to 3 match only when `fetch_vld` is high and `fetch_addr` equals their value. Data and register accesses never trigger them.
- R4: A flexible breakpoint in data mode matches only when `dmem_vld` is high and `dmem_addr` equals its value. Register accesses are ignored by it.
- R5: A flexible breakpoint in register mode matches only when `reg_vld` is high and `reg_id` equals its value. Data accesses are ignored by it.
- R6: While the global enable is 0, no match raises `brk_pulse`.
- R7: A match in cycle N gives `brk_pulse` high for exactly cycle N+1, with `brk_idx` holding the matching breakpoint's number.
- R8: When several breakpoints match in the same cycle, `brk_idx` reports the lowest-numbered one.
- R9: A breakpoint that has matched does not raise `brk_pulse` again while its qualifying strobe stays high. It can raise it again after that strobe has been low for at least one cycle.
- R10: `brk_idx` is 0 in every cycle in which `brk_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target: 0..5 breakpoint, 6 control word |
| cfg_wdata | input | 16 | Write data |
| fetch_vld | input | 1 | Instruction fetch valid |
| fetch_addr | input | 16 | Program execution address |
| dmem_vld | input | 1 | Data memory access valid |
| dmem_addr | input | 16 | Data memory access address |
| reg_vld | input | 1 | Register access valid |
| reg_id | input | 16 | Register access identifier |
| brk_pulse | output | 1 | One-cycle break request |
| brk_idx | output | 3 | Index of the breakpoint that fired |

## Verification
The bench builds the block with its default parameters: 16-bit values, four program-address breakpoints and two flexible ones. With these values every index from 0 to 5 can be reached, both flexible modes can be exercised side by side, and a program-address breakpoint can be made to collide with a flexible one in the same cycle. That collision exercises the priority order. With the default widths the bench can also test the one-cycle write-to-compare latency, the re-arm rule under a held strobe, and the case where the enable is switched while the bus is busy.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
   // Flexible breakpoint function select
   typedef enum logic {
      FLEX_DATA = 1'b0,
      FLEX_REG  = 1'b1
   } flex_mode_e;

   // Control word layout
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_MODE_LSB = 1;
endpackage

// File: rtl/bpm_regs.sv
module bpm_regs
   import bpm_pkg::*;
#(
   parameter int BP_W     = 16,
   parameter int NBP      = 6,
   parameter int NUM_FLEX = 2,
   parameter int SEL_W    = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [SEL_W-1:0]         cfg_sel,
   input  logic [BP_W-1:0]          cfg_wdata,
   output logic [NBP-1:0][BP_W-1:0] bp_val,
   output logic                     glb_en,
   output logic [NUM_FLEX-1:0]      flex_mode
);
   localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NBP);

   for (genvar i = 0; i < NBP; i++) begin : g_bp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bp_val[i] <= '0;
         else if (cfg_we && cfg_sel == SEL_W'(i))
            bp_val[i] <= cfg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en    <= 1'b0;
         flex_mode <= {NUM_FLEX{FLEX_DATA}};
      end else if (cfg_we && cfg_sel == CTRL_SEL) begin
         glb_en    <= cfg_wdata[CTRL_EN_BIT];
         flex_mode <= cfg_wdata[CTRL_MODE_LSB +: NUM_FLEX];
      end
   end
endmodule

// File: rtl/bpm_cmp.sv
module bpm_cmp #(
   parameter int BP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            glb_en,
   input  logic [BP_W-1:0] bp_val,
   input  logic            src_vld,
   input  logic [BP_W-1:0] src_val,
   output logic            rise
);
   logic hit;
   logic blocked_q;

   assign hit  = glb_en && src_vld && (src_val == bp_val);
   assign rise = hit && !blocked_q;

   // Stays blocked after a hit until the qualifying strobe drops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         blocked_q <= 1'b0;
      else if (!src_vld)
         blocked_q <= 1'b0;
      else if (hit)
         blocked_q <= 1'b1;
   end
endmodule

// File: rtl/bpm_prio.sv
module bpm_prio #(
   parameter int NBP   = 6,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBP-1:0]   rise,
   output logic             brk_pulse,
   output logic [IDX_W-1:0] brk_idx
);
   logic [IDX_W-1:0] low_idx;

   always_comb begin
      low_idx = '0;
      for (int i = NBP - 1; i >= 0; i--) begin
         if (rise[i]) low_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_pulse <= 1'b0;
         brk_idx   <= '0;
      end else begin
         brk_pulse <= |rise;
         brk_idx   <= low_idx;
      end
   end
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
   import bpm_pkg::*;
#(
   parameter int BP_W     = 16,
   parameter int NUM_PROG = 4,
   parameter int NUM_FLEX = 2,
   localparam int NBP     = NUM_PROG + NUM_FLEX,
   localparam int IDX_W   = $clog2(NBP),
   localparam int SEL_W   = $clog2(NBP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [BP_W-1:0]  cfg_wdata,
   input  logic             fetch_vld,
   input  logic [BP_W-1:0]  fetch_addr,
   input  logic             dmem_vld,
   input  logic [BP_W-1:0]  dmem_addr,
   input  logic             reg_vld,
   input  logic [BP_W-1:0]  reg_id,
   output logic             brk_pulse,
   output logic [IDX_W-1:0] brk_idx
);
   if (NUM_PROG < 1) begin : g_chk_prog
      $error("NUM_PROG must be at least 1");
   end
   if (NUM_FLEX < 1) begin : g_chk_flex
      $error("NUM_FLEX must be at least 1");
   end
   if (CTRL_MODE_LSB + NUM_FLEX > BP_W) begin : g_chk_ctrl
      $error("control word does not fit in BP_W");
   end

   logic [NBP-1:0][BP_W-1:0] bp_val;
   logic                     glb_en;
   logic [NUM_FLEX-1:0]      flex_mode;
   logic [NBP-1:0]           src_vld;
   logic [NBP-1:0][BP_W-1:0] src_val;
   logic [NBP-1:0]           rise;

   bpm_regs #(
      .BP_W(BP_W), .NBP(NBP), .NUM_FLEX(NUM_FLEX), .SEL_W(SEL_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .bp_val(bp_val), .glb_en(glb_en),
      .flex_mode(flex_mode)
   );

   for (genvar i = 0; i < NBP; i++) begin : g_slot
      if (i < NUM_PROG) begin : g_prog
         assign src_vld[i] = fetch_vld;
         assign src_val[i] = fetch_addr;
      end else begin : g_flex
         always_comb begin
            if (flex_mode[i-NUM_PROG] == FLEX_REG) begin
               src_vld[i] = reg_vld;
               src_val[i] = reg_id;
            end else begin
               src_vld[i] = dmem_vld;
               src_val[i] = dmem_addr;
            end
         end
      end

      bpm_cmp #(.BP_W(BP_W)) i_cmp (
         .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .bp_val(bp_val[i]),
         .src_vld(src_vld[i]), .src_val(src_val[i]), .rise(rise[i])
      );
   end

   bpm_prio #(.NBP(NBP), .IDX_W(IDX_W)) i_prio (
      .clk(clk), .rst_n(rst_n), .rise(rise),
      .brk_pulse(brk_pulse), .brk_idx(brk_idx)
   );
endmodule

// File: rtl/bpm_chk.sv
module bpm_chk #(
   parameter int NUM_PROG = 4,
   parameter int NBP      = 6,
   parameter int IDX_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fetch_vld,
   input logic             dmem_vld,
   input logic             reg_vld,
   input logic             glb_en,
   input logic             brk_pulse,
   input logic [IDX_W-1:0] brk_idx
);
   p_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(glb_en) |-> !brk_pulse);

   p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> $past(fetch_vld || dmem_vld || reg_vld));

   p_prog_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_pulse && int'(brk_idx) < NUM_PROG) |-> $past(fetch_vld));

   p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pulse |-> int'(brk_idx) < NBP);

   p_idx_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !brk_pulse |-> brk_idx == '0);
endmodule

bind brk_match_unit bpm_chk #(
   .NUM_PROG(NUM_PROG), .NBP(NBP), .IDX_W(IDX_W)
) i_bpm_chk (
   .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .dmem_vld(dmem_vld),
   .reg_vld(reg_vld), .glb_en(glb_en), .brk_pulse(brk_pulse),
   .brk_idx(brk_idx)
);

// File: tb/test_brk_match_unit.sv
`timescale 1ns/1ps
module test_brk_match_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_sel;
   logic [15:0] cfg_wdata;
   logic        fetch_vld, dmem_vld, reg_vld;
   logic [15:0] fetch_addr, dmem_addr, reg_id;
   logic        brk_pulse;
   logic [2:0]  brk_idx;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   brk_match_unit i_brk_match_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
      .dmem_vld(dmem_vld), .dmem_addr(dmem_addr), .reg_vld(reg_vld),
      .reg_id(reg_id), .brk_pulse(brk_pulse), .brk_idx(brk_idx)
   );

   // Drive one cycle of stimulus at a falling edge; return at the next one
   task automatic drive(input bit we, input logic [2:0] sel, input logic [15:0] wd,
                        input bit fv, input logic [15:0] fa,
                        input bit dv, input logic [15:0] da,
                        input bit rv, input logic [15:0] ri);
      cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
      fetch_vld = fv; fetch_addr = fa;
      dmem_vld = dv; dmem_addr = da;
      reg_vld = rv; reg_id = ri;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [15:0] wd);
      drive(1, sel, wd, 0, 16'h0, 0, 16'h0, 0, 16'h0);
   endtask

   task automatic idle();
      drive(0, 3'd0, 16'h0, 0, 16'h0, 0, 16'h0, 0, 16'h0);
   endtask

   task automatic check(input string req, input bit ep, input int ei);
      checks++;
      if (brk_pulse !== ep || int'(brk_idx) != ei) begin
         errors++;
         $display("FAIL %s: pulse=%0b idx=%0d expected pulse=%0b idx=%0d",
                  req, brk_pulse, brk_idx, ep, ei);
      end
   endtask

   task automatic t_reset();
      check("R1 reset outputs", 0, 0);
      // bp0 resets to 0 but enable is off
      drive(0, 3'd0, 16'h0, 1, 16'h0000, 0, 16'h0, 0, 16'h0);
      check("R1/R6 disabled after reset", 0, 0);
      idle();
   endtask

   task automatic t_load();
      wr(3'd0, 16'h1000); wr(3'd1, 16'h2000); wr(3'd2, 16'h3000);
      wr(3'd3, 16'h4000); wr(3'd4, 16'h5000); wr(3'd5, 16'h6000);
      wr(3'd6, 16'h0001);
      idle();
   endtask

   task automatic t_prog();
      drive(0, 3'd0, 16'h0, 1, 16'h3000, 0, 16'h0, 0, 16'h0);
      check("R3/R7 fetch hits bp2", 1, 2);
      idle();
      check("R7/R10 pulse lasts one cycle", 0, 0);
      drive(0, 3'd0, 16'h0, 1, 16'h4000, 0, 16'h0, 0, 16'h0);
      check("R3 fetch hits bp3", 1, 3);
      idle();
      drive(0, 3'd0, 16'h0, 0, 16'h0, 1, 16'h1000, 1, 16'h2000);
      check("R3 data/reg access ignored by bp0/bp1", 0, 0);
      idle();
   endtask

   task automatic t_flex_data();
      drive(0, 3'd0, 16'h0, 0, 16'h0, 1, 16'h5000, 0, 16'h0);
      check("R4 data access hits bp4", 1, 4);
      idle();
      drive(0, 3'd0, 16'h0, 0, 16'h0, 0, 16'h0, 1, 16'h6000);
      check("R4 reg access ignored in data mode", 0, 0);
      idle();
   endtask

   task automatic t_flex_reg();
      wr(3'd6, 16'h0005); // enable, bp5 register mode
      drive(0, 3'd0, 16'h0, 0, 16'h0, 0, 16'h0, 1, 16'h6000);
      check("R5 reg access hits bp5", 1, 5);
      idle();
      drive(0, 3'd0, 16'h0, 0, 16'h0, 1, 16'h6000, 0, 16'h0);
      check("R5 data access ignored in reg mode", 0, 0);
      idle();
      drive(0, 3'd0, 16'h0, 0, 16'h0, 1, 16'h5000, 0, 16'h0);
      check("R2/R4 bp4 still data mode", 1, 4);
      idle();
   endtask

   task automatic t_priority();
      drive(0, 3'd0, 16'h0, 1, 16'h2000, 1, 16'h5000, 0, 16'h0);
      check("R8 bp1 beats bp4", 1, 1);
      idle();
      wr(3'd2, 16'h2000);
      drive(0, 3'd0, 16'h0, 1, 16'h2000, 0, 16'h0, 0, 16'h0);
      check("R8 bp1 beats bp2", 1, 1);
      idle();
   endtask

   task automatic t_rearm();
      drive(0, 3'd0, 16'h0, 1, 16'h1000, 0, 16'h0, 0, 16'h0);
      check("R9 first hit", 1, 0);
      drive(0, 3'd0, 16'h0, 1, 16'h1000, 0, 16'h0, 0, 16'h0);
      check("R9 held strobe no repeat", 0, 0);
      drive(0, 3'd0, 16'h0, 1, 16'h1000, 0, 16'h0, 0, 16'h0);
      check("R9 held strobe still quiet", 0, 0);
      idle();
      check("R9 strobe low", 0, 0);
      drive(0, 3'd0, 16'h0, 1, 16'h1000, 0, 16'h0, 0, 16'h0);
      check("R9 re-armed after strobe low", 1, 0);
      idle();
   endtask

   task automatic t_write_timing();
      // Write bp3 and fetch the new value in the same cycle: old value used
      drive(1, 3'd3, 16'h7777, 1, 16'h7777, 0, 16'h0, 0, 16'h0);
      check("R2 write not yet visible", 0, 0);
      drive(0, 3'd0, 16'h0, 1, 16'h7777, 0, 16'h0, 0, 16'h0);
      check("R2 write visible next cycle", 1, 3);
      idle();
   endtask

   task automatic t_disable();
      wr(3'd6, 16'h0000);
      drive(0, 3'd0, 16'h0, 1, 16'h1000, 1, 16'h5000, 0, 16'h0);
      check("R6 disabled no pulse", 0, 0);
      idle();
      wr(3'd6, 16'h0001);
      drive(0, 3'd0, 16'h0, 1, 16'h1000, 0, 16'h0, 0, 16'h0);
      check("R6 re-enabled hit", 1, 0);
      idle();
   endtask

   initial begin
      rst_n = 1'b0;
      cfg_we = 0; cfg_sel = '0; cfg_wdata = '0;
      fetch_vld = 0; fetch_addr = '0;
      dmem_vld = 0; dmem_addr = '0;
      reg_vld = 0; reg_id = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_prog();
      t_flex_data();
      t_flex_reg();
      t_priority();
      t_rearm();
      t_write_timing();
      t_disable();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule